// File: doc/BRIEF.md
# Berger Code Concurrent Word Checker

This block watches an information word coming out of a programmable logic array, alongside a small check field that extra array lines produce for that word. The check field is meant to hold, in binary, how many bits of the information word are 0. The block works out that zero count again from the information bits. It then compares the two values bit by bit through a balanced tree of self-checking two-rail comparison cells. The result is a complementary pair of output rails.

The rails are read as a two-rail code. If the two rails differ, the word and its check field agree. If the two rails are equal, there is a fault, either in the array or in the checking path itself. The checking is purely combinational. A build-time parameter can add one register stage in front of the rails; this stage resets to the valid pattern rail_f = 0, rail_g = 1.

There is no back-pressure and no handshake. The block only observes the word, and it gives a verdict for every word presented to it. With the register stage enabled, that verdict appears one clock edge later.

Top module: `berger_checker`

## Requirements
- R1: The recomputed check symbol is the count of 0 bits in the DATA_W-bit information word. It is CHK_W = ceil(log2(DATA_W+1)) bits wide, so with DATA_W = 16 the field is 5 bits.
- R2: When the check field equals the zero count of the information word, the rails are complementary (rail_f != rail_g).
- R3: When the check field differs from the zero count in any way, the rails are equal (rail_f == rail_g). This includes field values above DATA_W, such as 31.
- R4: Both extreme words are accepted with their correct fields: an all-zero word with check DATA_W, and an all-one word with check 0.
- R5: Flipping any single information bit while the original check field is kept makes the rails equal.
- R6: With REG_OUT = 1, the rails show the verdict for the inputs present at the previous rising clock edge. With REG_OUT = 0, the rails follow the inputs without a clock.
- R7: While rst_ni is low, the registered rails hold rail_f = 0, rail_g = 1, whatever the inputs are.
- R8: For a valid word, rail_f equals the XOR of all check-field bits. Each comparison pair places the received check bit on its first rail, and every code-word cell result takes the XOR of its inputs' first rails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional rail register |
| rst_ni | input | 1 | Asynchronous active-low reset of the rail register |
| info_i | input | DATA_W | Information word from the logic array |
| chk_i | input | CHK_W | Check field from the extra array lines |
| rail_f_o | output | 1 | First verdict rail |
| rail_g_o | output | 1 | Second verdict rail; differs from rail_f_o when the word is valid |

## Verification
The cases that are hardest to reach from the ports are the ones where the check field is nearly right. In these words one information bit is flipped or one check bit is toggled, so the zero count is off by a single unit or by a single power of two. Such words only show up when the stimulus is built on purpose. The bench therefore starts from correctly encoded random words, corrupts exactly one information bit or one check bit, and also drives field values above DATA_W. It also checks the polarity of the valid rail against the parity of the check field, so a swapped cell output cannot hide behind a correct valid/faulty decision.

// File: rtl/berger_pkg.sv
package berger_pkg;

  // Width of the zero-count field needed to represent counts 0..n.
  function automatic int chk_width(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  // One two-rail signal: a code word has f != g.
  typedef struct packed {
    logic f;
    logic g;
  } rail_t;

  localparam rail_t RAIL_IDLE = '{f: 1'b0, g: 1'b1};

endpackage

// File: rtl/berger_zero_count.sv
module berger_zero_count #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic [DATA_W-1:0] word_i,
  output logic [CNT_W-1:0]  zeros_o
);

  // Sum the inverted bits one at a time.
  always_comb begin
    zeros_o = '0;
    for (int b = 0; b < DATA_W; b++) begin
      zeros_o = zeros_o + CNT_W'(!word_i[b]);
    end
  end

endmodule

// File: rtl/berger_tworail_cell.sv
module berger_tworail_cell
  import berger_pkg::*;
(
  input  rail_t a_i,
  input  rail_t b_i,
  output rail_t y_o
);

  // (01,01)->01  (10,10)->01  (10,01)->10  (01,10)->10; a noncode input gives f == g.
  assign y_o.f = (a_i.f & b_i.g) | (a_i.g & b_i.f);
  assign y_o.g = (a_i.f & b_i.f) | (a_i.g & b_i.g);

endmodule

// File: rtl/berger_tworail_tree.sv
module berger_tworail_tree
  import berger_pkg::*;
#(
  parameter int PAIRS = 5
) (
  input  rail_t [PAIRS-1:0] leaf_i,
  output rail_t             root_o
);

  localparam int DEPTH  = (PAIRS > 1) ? $clog2(PAIRS) : 0;
  localparam int LEAVES = 1 << DEPTH;
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap-ordered nodes: node k has its children at 2k+1 and 2k+2.
  rail_t node [NODES];

  // Leaf positions that have no pair are padded with a fixed valid pair.
  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < PAIRS) begin : g_used
      assign node[LEAVES-1+j] = leaf_i[j];
    end else begin : g_pad
      assign node[LEAVES-1+j] = RAIL_IDLE;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_cell
    berger_tworail_cell u_cell (
      .a_i(node[2*k+1]),
      .b_i(node[2*k+2]),
      .y_o(node[k])
    );
  end

  assign root_o = node[0];

endmodule

// File: rtl/berger_rail_stage.sv
module berger_rail_stage
  import berger_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  rail_t pair_i,
  output rail_t pair_o
);

  if (REG_OUT) begin : g_reg
    rail_t held_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) held_q <= RAIL_IDLE;
      else         held_q <= pair_i;
    end
    assign pair_o = held_q;
  end else begin : g_comb
    assign pair_o = pair_i;
  end

endmodule

// File: rtl/berger_checker.sv
module berger_checker
  import berger_pkg::*;
#(
  parameter int  DATA_W  = 16,
  parameter bit  REG_OUT = 1'b1,
  localparam int CHK_W   = chk_width(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] info_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic              rail_f_o,
  output logic              rail_g_o
);

  logic [CHK_W-1:0] zero_cnt;
  rail_t [CHK_W-1:0] cmp_pair;
  rail_t comb_pair;
  rail_t out_pair;

  berger_zero_count #(.DATA_W(DATA_W), .CNT_W(CHK_W)) u_count (
    .word_i (info_i),
    .zeros_o(zero_cnt)
  );

  // Each pair joins a received check bit with the inverted recomputed bit.
  for (genvar i = 0; i < CHK_W; i++) begin : g_pair
    assign cmp_pair[i].f = chk_i[i];
    assign cmp_pair[i].g = ~zero_cnt[i];
  end

  berger_tworail_tree #(.PAIRS(CHK_W)) u_tree (
    .leaf_i(cmp_pair),
    .root_o(comb_pair)
  );

  berger_rail_stage #(.REG_OUT(REG_OUT)) u_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pair_i(comb_pair),
    .pair_o(out_pair)
  );

  assign rail_f_o = out_pair.f;
  assign rail_g_o = out_pair.g;

endmodule

// File: rtl/berger_checker_sva.sv
module berger_checker_sva #(
  parameter int DATA_W  = 16,
  parameter bit REG_OUT = 1'b1,
  parameter int CHK_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] info_i,
  input logic [CHK_W-1:0]  chk_i,
  input logic [CHK_W-1:0]  zc_i,
  input logic              pf_i,
  input logic              pg_i,
  input logic              rail_f_o,
  input logic              rail_g_o
);

  // R1
  zero_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(zc_i) == DATA_W - $countones(info_i));

  // R2
  valid_complement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(chk_i) == DATA_W - $countones(info_i)) |-> (pf_i != pg_i));

  // R3
  fault_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(chk_i) != DATA_W - $countones(info_i)) |-> (pf_i == pg_i));

  // R8
  valid_polarity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_i != pg_i) |-> (pf_i == ^chk_i));

  if (REG_OUT) begin : g_reg_chk
    // R6
    reg_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> ({rail_f_o, rail_g_o} == $past({pf_i, pg_i})));
  end

endmodule

bind berger_checker berger_checker_sva #(
  .DATA_W (DATA_W),
  .REG_OUT(REG_OUT),
  .CHK_W  (CHK_W)
) u_sva (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .info_i  (info_i),
  .chk_i   (chk_i),
  .zc_i    (zero_cnt),
  .pf_i    (comb_pair.f),
  .pg_i    (comb_pair.g),
  .rail_f_o(rail_f_o),
  .rail_g_o(rail_g_o)
);

// File: tb/berger_checker_bench.sv
module berger_checker_bench;

  localparam int  CLK_PERIOD = 10;
  localparam int  DATA_W     = 16;
  localparam int  CHK_W      = $clog2(DATA_W + 1);
  localparam int  MAX_CYC    = 200000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] info = '0;
  logic [CHK_W-1:0]  chk = '1;
  logic              rf, rg;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    bit    valid;
    bit    par;
    string tag;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  berger_checker #(.DATA_W(DATA_W), .REG_OUT(1'b1)) u_berger_checker (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .info_i  (info),
    .chk_i   (chk),
    .rail_f_o(rf),
    .rail_g_o(rg)
  );

  function automatic int zeros_of(input logic [DATA_W-1:0] w);
    int z = 0;
    for (int b = 0; b < DATA_W; b++) if (!w[b]) z++;
    return z;
  endfunction

  task automatic send(input logic [DATA_W-1:0] w, input logic [CHK_W-1:0] c, input string tag);
    exp_t e;
    @(negedge clk);
    info = w;
    chk  = c;
    e.valid = (int'(c) == zeros_of(w));
    e.par   = ^c;
    e.tag   = tag;
    sb_q.push_back(e);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Monitor: the registered verdict settles after the rising edge that follows a push.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_cmp++;
      if (e.valid) begin
        if (!(rf != rg && rf == e.par)) begin
          n_bad++;
          $display("FAIL %s: rails=%b%b expected valid %b%b", e.tag, rf, rg, e.par, !e.par);
        end
      end else if (rf != rg) begin
        n_bad++;
        $display("FAIL %s: rails=%b%b expected equal rails", e.tag, rf, rg);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run ended=0 expected=1");
      report();
    end
  end

  initial begin
    // R7: a faulty word while reset is held must still show the idle valid pair.
    info = 16'h0000;
    chk  = 5'd3;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      n_cmp++;
      if (!(rf == 1'b0 && rg == 1'b1)) begin
        n_bad++;
        $display("FAIL R7: rails=%b%b expected 01", rf, rg);
      end
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R8 R6: correctly encoded random words, one per cycle.
    for (int k = 0; k < 40; k++) begin
      logic [DATA_W-1:0] w = DATA_W'($urandom);
      send(w, CHK_W'(zeros_of(w)), "R1/R2/R8/R6 encoded");
    end

    // R4: the two extreme words.
    send('0, CHK_W'(DATA_W), "R4 all-zero");
    send('1, '0, "R4 all-one");
    send(16'h000D, CHK_W'(13), "R1 sparse");

    // R5: one flipped information bit under the original field.
    for (int b = 0; b < DATA_W; b++) begin
      logic [DATA_W-1:0] w = DATA_W'($urandom);
      send(w ^ (DATA_W'(1) << b), CHK_W'(zeros_of(w)), "R5 info flip");
    end

    // R3: one toggled check bit, and fields beyond DATA_W.
    for (int b = 0; b < CHK_W; b++) begin
      logic [DATA_W-1:0] w = DATA_W'($urandom);
      send(w, CHK_W'(zeros_of(w)) ^ (CHK_W'(1) << b), "R3 check flip");
    end
    send('0, '1, "R3 field 31");
    send('1, CHK_W'(DATA_W + 1), "R3 field 17");
    send('0, CHK_W'(DATA_W - 1), "R3 off by one");

    // R2: back-to-back alternation between valid and faulty words.
    for (int k = 0; k < 10; k++) begin
      logic [DATA_W-1:0] w = DATA_W'($urandom);
      send(w, CHK_W'(zeros_of(w)) + CHK_W'(k % 2), "R2/R3 alternate");
    end

    repeat (3) @(negedge clk);
    done = 1'b1;
    report();
  end

endmodule